// File: doc/BRIEF.md
# Relaxation DAC Bit-Serial Driver

This block turns a parallel N-bit code into the timed serial waveform that drives a three-state buffer in front of a first-order RC network. A conversion starts with a capacitor clear phase. The buffer then drives one code bit per bit interval, lowest bit first, with every interval the same programmable number of system clocks. After the last bit the buffer is placed in high impedance, so the capacitor keeps its voltage until the next conversion.

A start strobe seen while the driver is idle captures the code, the bit-interval length and the clear-phase length. All three are held for the whole conversion. A start strobe that arrives during a conversion is dropped. A one-clock done pulse marks the moment the buffer goes to high impedance.

Top module: `rdac_serial_drv`

## Requirements
- R1: While reset is held, and afterwards until the first start, the outputs are drv_hiz=1, drv_data=0, cap_clear=0, busy=0 and done=0.
- R2: A start sampled while busy=0 begins the clear phase in the next cycle. The clear phase lasts L clocks, where L is the captured rst_len, or 1 when rst_len is 0. During the clear phase cap_clear=1, drv_hiz=0, drv_data=0 and busy=1.
- R3: After the clear phase, code bit i (bit 0 first, bit N-1 last) is driven on drv_data with drv_hiz=0, cap_clear=0 and busy=1. A 1 bit gives drv_data=1 and a 0 bit gives drv_data=0. Counting from the first clear cycle as cycle 0, bit i occupies cycles L+i*P to L+(i+1)*P-1.
- R4: Every bit interval lasts exactly P clocks. P is the captured period, or 1 when period is 0.
- R5: In cycle L+N*P the driver enters hold, with drv_hiz=1, drv_data=0 and busy=0. done is 1 in that cycle only.
- R6: code, period and rst_len are captured when the start is accepted. Later changes to them do not alter the running conversion.
- R7: A start sampled while busy=1 is ignored. It neither restarts nor lengthens the conversion.
- R8: Hold persists, with done=0, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request strobe |
| code | input | NBITS | Code to convert |
| period | input | PER_W | Bit interval length in clocks (0 acts as 1) |
| rst_len | input | RST_W | Clear phase length in clocks (0 acts as 1) |
| drv_data | output | 1 | Buffer data level (1 = supply, 0 = ground) |
| drv_hiz | output | 1 | Buffer disable, active high (high impedance) |
| cap_clear | output | 1 | Capacitor clear request |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse on entering hold |

## Verification
Every output comes from registers. A start sampled at an edge therefore shows up as the clear phase one cycle later. Bit i appears L+i*P cycles after that first clear cycle, and the done pulse appears L+N*P cycles after it. The driver task builds the complete expected trace for each conversion, one item per cycle, before the start edge. The monitor pops one item per clock, a quarter period after each rising edge, so every comparison lands in the exact cycle the requirements name. Mid-conversion input changes and extra start strobes go into the stimulus but not into the trace, so any effect they have shows up as a mismatch.

// File: rtl/rdac_pkg.sv
// Shared types for the relaxation DAC serial driver.
package rdac_pkg;
    // Conversion phase: hold (high impedance), capacitor clear, bit drive
    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_CLR  = 2'd1,
        PH_BITS = 2'd2
    } rdac_phase_e;
endpackage

// File: rtl/rdac_tick_ctr.sv
// Down-counter that times the clear phase and each bit interval.
// Assumes: reload_val is the interval length minus one; expire is high
// in the last cycle of the interval.
module rdac_tick_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [CW-1:0] reload_val,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    // Purpose: reload at phase boundaries, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= reload_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Purpose: flag the final cycle of the current interval
    always_comb begin
        expire = (cnt_q == '0);
    end
endmodule

// File: rtl/rdac_shifter.sv
// Shift register that presents code bits lowest first.
// Assumes: load and advance are never high in the same cycle.
module rdac_shifter #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_word,
    input  logic         advance,
    output logic         lsb
);
    logic [N-1:0] sr_q;

    // Purpose: capture the code at start and shift right per bit interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_word;
        end else if (advance) begin
            sr_q <= {1'b0, sr_q[N-1:1]};
        end
    end

    // Purpose: expose the bit currently being driven
    always_comb begin
        lsb = sr_q[0];
    end
endmodule

// File: rtl/rdac_seq_fsm.sv
// Phase sequencer: hold -> clear -> N bit intervals -> hold.
// Assumes: expire comes from rdac_tick_ctr; period and rst_len are
// sampled only when a start is accepted in hold.
module rdac_seq_fsm
    import rdac_pkg::*;
#(
    parameter int N     = 10,
    parameter int PER_W = 16,
    parameter int RST_W = 8,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] period,
    input  logic [RST_W-1:0] rst_len,
    input  logic             expire,
    output rdac_phase_e      phase,
    output logic             reload,
    output logic [CW-1:0]    reload_val,
    output logic             load,
    output logic             advance,
    output logic             done
);
    localparam int          IDX_W    = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    rdac_phase_e      phase_q;
    logic [CW-1:0]    per_m1_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             accept;
    logic [CW-1:0]    per_ext;
    logic [CW-1:0]    rl_ext;
    logic [CW-1:0]    per_m1;
    logic [CW-1:0]    rl_m1;
    logic             last_bit;

    // Purpose: widen and convert lengths to count-down limits (0 acts as 1)
    always_comb begin
        per_ext  = CW'(period);
        rl_ext   = CW'(rst_len);
        per_m1   = (per_ext == '0) ? '0 : per_ext - CW'(1);
        rl_m1    = (rl_ext == '0) ? '0 : rl_ext - CW'(1);
        accept   = start && (phase_q == PH_HOLD);
        last_bit = (idx_q == LAST_IDX);
    end

    // Purpose: derive counter reload and shifter controls for this cycle
    always_comb begin
        reload     = 1'b0;
        reload_val = '0;
        load       = 1'b0;
        advance    = 1'b0;
        if (accept) begin
            load       = 1'b1;
            reload     = 1'b1;
            reload_val = rl_m1;
        end else if (phase_q == PH_CLR && expire) begin
            reload     = 1'b1;
            reload_val = per_m1_q;
        end else if (phase_q == PH_BITS && expire && !last_bit) begin
            reload     = 1'b1;
            reload_val = per_m1_q;
            advance    = 1'b1;
        end
    end

    // Purpose: advance the phase, bit index and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_HOLD;
            per_m1_q <= '0;
            idx_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_HOLD: begin
                    if (accept) begin
                        phase_q  <= PH_CLR;
                        per_m1_q <= per_m1;
                        idx_q    <= '0;
                    end
                end
                PH_CLR: begin
                    if (expire) begin
                        phase_q <= PH_BITS;
                    end
                end
                PH_BITS: begin
                    if (expire) begin
                        if (last_bit) begin
                            phase_q <= PH_HOLD;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: phase_q <= PH_HOLD;
            endcase
        end
    end

    // Purpose: publish registered state
    always_comb begin
        phase = phase_q;
        done  = done_q;
    end
endmodule

// File: rtl/rdac_serial_drv.sv
// Top of the relaxation DAC serial driver. Clears the capacitor, drives
// the code bits lowest first for equal intervals, then disables the buffer.
// Assumes: all outputs registered-state based; synchronous active-low reset.
module rdac_serial_drv
    import rdac_pkg::*;
#(
    parameter int NBITS = 10,
    parameter int PER_W = 16,
    parameter int RST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] code,
    input  logic [PER_W-1:0] period,
    input  logic [RST_W-1:0] rst_len,
    output logic             drv_data,
    output logic             drv_hiz,
    output logic             cap_clear,
    output logic             busy,
    output logic             done
);
    localparam int CW = (PER_W > RST_W) ? PER_W : RST_W;

    rdac_phase_e   phase;
    logic          reload;
    logic [CW-1:0] reload_val;
    logic          load;
    logic          advance;
    logic          expire;
    logic          lsb;

    rdac_seq_fsm #(
        .N     (NBITS),
        .PER_W (PER_W),
        .RST_W (RST_W),
        .CW    (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .period     (period),
        .rst_len    (rst_len),
        .expire     (expire),
        .phase      (phase),
        .reload     (reload),
        .reload_val (reload_val),
        .load       (load),
        .advance    (advance),
        .done       (done)
    );

    rdac_tick_ctr #(
        .CW (CW)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (reload),
        .reload_val (reload_val),
        .expire     (expire)
    );

    rdac_shifter #(
        .N (NBITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (code),
        .advance   (advance),
        .lsb       (lsb)
    );

    // Purpose: decode buffer controls from the current phase
    always_comb begin
        drv_hiz   = (phase == PH_HOLD);
        cap_clear = (phase == PH_CLR);
        busy      = (phase != PH_HOLD);
        drv_data  = (phase == PH_BITS) && lsb;
    end
endmodule

// File: rtl/rdac_serial_drv_chk.sv
// Property checker for rdac_serial_drv, attached by bind.
module rdac_serial_drv_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic drv_data,
    input logic drv_hiz,
    input logic cap_clear,
    input logic busy,
    input logic done
);
    AST_HIZ_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hiz |-> !drv_data); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(drv_hiz)); // R5
    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cap_clear |-> (!drv_hiz && !drv_data && busy)); // R2
    AST_CLEAR_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_clear) |-> $past(start)); // R2
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !$rose(cap_clear)); // R7
    AST_BITS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_clear) |-> (busy && !drv_hiz)); // R3
endmodule

bind rdac_serial_drv rdac_serial_drv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .drv_data  (drv_data),
    .drv_hiz   (drv_hiz),
    .cap_clear (cap_clear),
    .busy      (busy),
    .done      (done)
);

// File: tb/rdac_serial_drv_tb.sv
// Scoreboard bench: the driver queues the expected per-cycle outputs and
// the monitor compares them a quarter period after each rising edge.
module rdac_serial_drv_tb;
    localparam int CLK_P = 10;
    localparam int NB    = 10;
    localparam int PW    = 16;
    localparam int RW    = 8;

    typedef struct {
        logic [4:0] v;   // {done, busy, cap_clear, drv_hiz, drv_data}
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] code = '0;
    logic [PW-1:0] period = '0;
    logic [RW-1:0] rst_len = '0;
    logic          drv_data, drv_hiz, cap_clear, busy, done;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;

    rdac_serial_drv #(.NBITS(NB), .PER_W(PW), .RST_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .code(code),
        .period(period), .rst_len(rst_len), .drv_data(drv_data),
        .drv_hiz(drv_hiz), .cap_clear(cap_clear), .busy(busy), .done(done)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [4:0] outs();
        return {done, busy, cap_clear, drv_hiz, drv_data};
    endfunction

    task automatic check(input logic [4:0] act, input logic [4:0] expv, input string tag);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: outputs {done,busy,clr,hiz,data} actual=%b expected=%b at %0t",
                     tag, act, expv, $time);
        end
    endtask

    task automatic push(input logic [4:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: queue the expected trace, issue start, disturb inputs mid-run
    task automatic convert(input logic [NB-1:0] c, input int per, input int rl);
        int L;
        int P;
        int total;
        L = (rl == 0) ? 1 : rl;
        P = (per == 0) ? 1 : per;
        @(negedge clk);
        for (int k = 0; k < L; k++) push(5'b01100, "R2");
        for (int i = 0; i < NB; i++)
            for (int k = 0; k < P; k++)
                push({4'b0100, c[i]}, (k == 0) ? "R3" : "R4");
        push(5'b10010, "R5");
        push(5'b00010, "R8");
        push(5'b00010, "R8");
        total = L + NB * P + 3;
        start   = 1'b1;
        code    = c;
        period  = PW'(per);
        rst_len = RW'(rl);
        for (int j = 1; j <= total; j++) begin
            @(negedge clk);
            start = 1'b0;
            if (j == 1) begin       // R6: captured values must not change
                code    = ~c;
                period  = PW'(per + 7);
                rst_len = RW'(rl + 9);
            end
            if (j == 3) start = 1'b1;   // R7: start while busy
        end
        start = 1'b0;
    endtask

    // Monitor: one comparison per cycle, away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(outs(), e.v, e.tag);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #(CLK_P/4);
        check(outs(), 5'b00010, "R1");   // during reset
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check(outs(), 5'b00010, "R1");   // idle after reset
        convert(10'h2B5, 3, 2);
        convert(10'h3FF, 1, 1);
        convert(10'h000, 0, 0);
        convert(10'h201, 5, 4);
        convert(10'h155, 2, 3);
        repeat (5) @(negedge clk);
        #(CLK_P/4);
        check(outs(), 5'b00010, "R8");
        if (exp_q.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL scoreboard: leftover actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule